// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an asynchronous serial line into characters. It watches the idle-high line for a falling edge and confirms the start bit at its midpoint. It then takes each bit as a 2-of-3 vote of samples around the bit centre, using a 16x oversampling tick. The finished character goes into a one-deep holding register. The frame shape is set at run time: 5 to 9 data bits, sent least significant bit first, an optional even or odd parity bit, and a stop bit.

Three error flags travel with each stored character: bad stop bit, parity mismatch, and "the previous character was never read". All of them describe the character currently in the holding register. A single read strobe clears the ready flag and every error flag together. An interrupt request goes high while a character is waiting, provided its enable is set.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, rx_ready, frame_err, parity_err, overrun and irq are 0, and rx_data and rx_bit9 read 0.
- R2: A character starts only on a high-to-low change of the line. If the line has returned high at the start bit's midpoint, the event is dropped as a glitch, no character is stored, and the receiver is ready for the next falling edge.
- R3: Data bits arrive least significant bit first. char_len gives the count: values 5 to 9 are used as given, values below 5 act as 5, and values above 9 act as 9. Unused upper bits of rx_data read 0. The ninth bit appears on rx_bit9, which reads 0 unless 9 bits are configured.
- R4: par_mode selects the parity check: 2'b00 means no parity bit, 2'b01 also means no parity bit, 2'b10 means even parity, and 2'b11 means odd parity. If the received parity bit makes the total count of ones over data and parity wrong for the chosen mode, parity_err is set with the character.
- R5: frame_err is set with the character when the first stop bit is sampled low.
- R6: rx_ready rises once a character is stored and stays high until it is read. irq equals irq_en AND rx_ready.
- R7: If a character completes while rx_ready is already high and no read occurs in that cycle, the new character replaces the old one and overrun is set.
- R8: A one-cycle pulse on rd_strobe clears rx_ready, frame_err, parity_err and overrun. It leaves rx_data and rx_bit9 unchanged.
- R9: While rx_en is low, no character is received. A frame in progress when rx_en falls is abandoned and never stored.
- R10: One bit lasts 16*(baud_div+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| baud_div | input | DIV_W | Oversampling tick divider; one tick every baud_div+1 clocks |
| char_len | input | 4 | Data bits per character (5 to 9, clamped) |
| par_mode | input | 2 | Parity mode: 00/01 none, 10 even, 11 odd |
| rx_line | input | 1 | Serial input line, idle high |
| rd_strobe | input | 1 | Read pulse; clears ready and error flags |
| irq_en | input | 1 | Receive-complete interrupt enable |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit9 | output | 1 | Ninth received data bit |
| rx_ready | output | 1 | Unread character held |
| frame_err | output | 1 | Stop bit of held character was low |
| parity_err | output | 1 | Parity mismatch on held character |
| overrun | output | 1 | Held character overwrote an unread one |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench sends a start pulse that is only a quarter of a bit long. A receiver that skipped the midpoint check would store a bogus all-ones character. It also sends 5-, 9- and clamped-length frames. A receiver that got the bit count wrong would shift bits into the wrong positions, or would read the stop bit as data and raise a false frame error. Frames are sent with both correct and deliberately wrong parity bits in both modes, and in the reserved mode, where a receiver that expected a parity bit would take the stop bit as parity. The bench lets two characters arrive with no read between them, and drops the enable in the middle of a frame. These catch a receiver that misses the overrun or keeps the old data, and one that still stores the half-received character.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_RSVD = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_ODD  = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_PAR,
    RS_STOP
  } rx_state_e;

  localparam int unsigned MAX_BITS = 9;

  // 2-of-3 majority of three line samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Character length forced into the 5..9 range
  function automatic logic [3:0] clamp_len(input logic [3:0] req);
    if (req < 4'd5) return 4'd5;
    if (req > 4'd9) return 4'd9;
    return req;
  endfunction

  // Parity bit a sender would attach; unused data bits are zero
  function automatic logic want_parity(input logic [MAX_BITS-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_q == '0) cnt_q <= div;
    else                 cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                tick,
  input  logic                line,
  input  logic [3:0]          len,
  input  par_mode_e           pmode,
  output logic                done,
  output logic [MAX_BITS-1:0] done_data,
  output logic                done_ferr,
  output logic                done_perr,
  output logic                busy,
  output logic                glitch
);
  rx_state_e           state_q;
  logic [3:0]          sub_q;
  logic [3:0]          bitn_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic                prev_q, s_a_q, s_b_q, pbit_q;
  logic                v_now, decide, par_on, fall;

  assign v_now  = vote3(s_a_q, s_b_q, line);
  assign decide = en && tick && (sub_q == 4'd9);
  assign par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
  assign fall   = prev_q && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      sub_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      prev_q  <= 1'b1;
      s_a_q   <= 1'b1;
      s_b_q   <= 1'b1;
      pbit_q  <= 1'b0;
    end else begin
      if (tick) prev_q <= line;
      if (!en) begin
        state_q <= RS_IDLE;
      end else if (tick) begin
        if (state_q == RS_IDLE) begin
          if (fall) begin
            state_q <= RS_START;
            sub_q   <= 4'd1;
          end
        end else begin
          sub_q <= sub_q + 4'd1;
          if (sub_q == 4'd7) s_a_q <= line;
          if (sub_q == 4'd8) s_b_q <= line;
          if (sub_q == 4'd9) begin
            unique case (state_q)
              RS_START: begin
                if (v_now) state_q <= RS_IDLE;
                else begin
                  state_q <= RS_DATA;
                  bitn_q  <= '0;
                  shreg_q <= '0;
                end
              end
              RS_DATA: begin
                shreg_q[bitn_q] <= v_now;
                if (bitn_q == len - 4'd1) state_q <= par_on ? RS_PAR : RS_STOP;
                else                      bitn_q  <= bitn_q + 4'd1;
              end
              RS_PAR: begin
                pbit_q  <= v_now;
                state_q <= RS_STOP;
              end
              RS_STOP: state_q <= RS_IDLE;
              default: state_q <= RS_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign done      = decide && (state_q == RS_STOP);
  assign glitch    = decide && (state_q == RS_START) && v_now;
  assign done_ferr = !v_now;
  assign done_perr = par_on && (pbit_q != want_parity(shreg_q, pmode == PAR_ODD));
  assign done_data = shreg_q;
  assign busy      = (state_q != RS_IDLE);
endmodule

// File: rtl/srx_hold_reg.sv
module srx_hold_reg
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] ld_data,
  input  logic                ld_ferr,
  input  logic                ld_perr,
  input  logic                rd,
  output logic [MAX_BITS-1:0] data,
  output logic                ready,
  output logic                ferr,
  output logic                perr,
  output logic                ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      data  <= ld_data;
      ready <= 1'b1;
      ferr  <= ld_ferr;
      perr  <= ld_perr;
      ovr   <= ready && !rd;
    end else if (rd) begin
      ready <= 1'b0;
      ferr  <= 1'b0;
      perr  <= 1'b0;
      ovr   <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [3:0]       char_len,
  input  logic [1:0]       par_mode,
  input  logic             rx_line,
  input  logic             rd_strobe,
  input  logic             irq_en,
  output logic [7:0]       rx_data,
  output logic             rx_bit9,
  output logic             rx_ready,
  output logic             frame_err,
  output logic             parity_err,
  output logic             overrun,
  output logic             irq
);
  logic                tick, line_s;
  logic                char_done, busy, glitch_seen;
  logic                c_ferr, c_perr;
  logic [MAX_BITS-1:0] c_data, held;
  logic [3:0]          len_eff;

  assign len_eff = clamp_len(char_len);

  srx_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick)
  );

  srx_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  srx_frame_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .line(line_s),
    .len(len_eff), .pmode(par_mode_e'(par_mode)),
    .done(char_done), .done_data(c_data), .done_ferr(c_ferr), .done_perr(c_perr),
    .busy(busy), .glitch(glitch_seen)
  );

  srx_hold_reg hold_i (
    .clk(clk), .rst_n(rst_n), .load(char_done), .ld_data(c_data),
    .ld_ferr(c_ferr), .ld_perr(c_perr), .rd(rd_strobe),
    .data(held), .ready(rx_ready), .ferr(frame_err), .perr(parity_err), .ovr(overrun)
  );

  assign rx_data = held[7:0];
  assign rx_bit9 = held[8];
  assign irq     = irq_en & rx_ready;
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_strobe,
  input logic       char_done,
  input logic       glitch_seen,
  input logic       busy,
  input logic       rx_ready,
  input logic       frame_err,
  input logic       parity_err,
  input logic       overrun,
  input logic       rx_bit9,
  input logic [3:0] len_eff
);
  AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> rx_ready); // R6
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rd_strobe |=> rx_ready); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !char_done |=> !rx_ready && !frame_err && !parity_err && !overrun); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && rx_ready && !rd_strobe |=> overrun); // R7
  AST_FLAGS_NEED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err || parity_err || overrun) |-> rx_ready); // R8
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !busy); // R9
  AST_GLITCH_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_seen |=> !busy); // R2
  AST_NINTH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    char_done && (len_eff != 4'd9) |=> !rx_bit9); // R3
endmodule

bind serial_rx_core serial_rx_core_chk chk_i (.*);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_en = 1'b1;
  logic [DIV_W-1:0] baud_div = '0;
  logic [3:0]       char_len = 4'd8;
  logic [1:0]       par_mode = 2'b00;
  logic             rx_line = 1'b1;
  logic             rd_strobe = 1'b0;
  logic             irq_en = 1'b0;
  logic [7:0]       rx_data;
  logic             rx_bit9, rx_ready, frame_err, parity_err, overrun, irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_core #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_div(baud_div),
    .char_len(char_len), .par_mode(par_mode), .rx_line(rx_line),
    .rd_strobe(rd_strobe), .irq_en(irq_en), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err),
    .parity_err(parity_err), .overrun(overrun), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_line = b;
    repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  // nbits data bits LSB first, optional parity bit, one stop bit, then idle
  task automatic send_frame(input logic [8:0] val, input int nbits, input bit par_on,
                            input bit par_odd, input bit par_bad, input logic stop_lvl);
    logic p;
    p = 1'b0;
    for (int i = 0; i < nbits; i++) p = p ^ val[i];
    p = p ^ par_odd ^ par_bad;
    drive_bit(1'b0);
    for (int i = 0; i < nbits; i++) drive_bit(val[i]);
    if (par_on) drive_bit(p);
    drive_bit(stop_lvl);
    idle_bits(2);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", rx_ready, 0);
    check("R1 flags", {frame_err, parity_err, overrun, irq}, 0);
    check("R1 data", {rx_bit9, rx_data}, 0);
  endtask

  task automatic t_basic();
    char_len = 4'd8; par_mode = 2'b00; irq_en = 1'b0;
    send_frame(9'h0A5, 8, 0, 0, 0, 1'b1);
    check("R3 8-bit data", rx_data, 8'hA5);
    check("R6 ready", rx_ready, 1);
    check("R6 irq masked", irq, 0);
    @(negedge clk) irq_en = 1'b1;
    #1 check("R6 irq enabled", irq, 1);
    check("R5 no ferr", frame_err, 0);
    do_read();
    check("R8 ready cleared", rx_ready, 0);
    check("R8 data kept", rx_data, 8'hA5);
    check("R6 irq drops", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_lengths();
    char_len = 4'd5;
    send_frame(9'h016, 5, 0, 0, 0, 1'b1);
    check("R3 5-bit data", {rx_bit9, rx_data}, 9'h016);
    check("R3 5-bit no ferr", frame_err, 0);
    do_read();
    char_len = 4'd9;
    send_frame(9'h1C3, 9, 0, 0, 0, 1'b1);
    check("R3 9-bit data", rx_data, 8'hC3);
    check("R3 ninth bit", rx_bit9, 1);
    do_read();
    char_len = 4'd2;
    send_frame(9'h00D, 5, 0, 0, 0, 1'b1);
    check("R3 clamp low", {rx_bit9, rx_data}, 9'h00D);
    check("R3 clamp low ferr", frame_err, 0);
    do_read();
    char_len = 4'd15;
    send_frame(9'h155, 9, 0, 0, 0, 1'b1);
    check("R3 clamp high", {rx_bit9, rx_data}, 9'h155);
    do_read();
    char_len = 4'd8;
  endtask

  task automatic t_parity();
    par_mode = 2'b10;
    send_frame(9'h037, 8, 1, 0, 0, 1'b1);
    check("R4 even ok", parity_err, 0);
    check("R4 even data", rx_data, 8'h37);
    do_read();
    send_frame(9'h037, 8, 1, 0, 1, 1'b1);
    check("R4 even bad", parity_err, 1);
    do_read();
    par_mode = 2'b11;
    send_frame(9'h0E1, 8, 1, 1, 0, 1'b1);
    check("R4 odd ok", parity_err, 0);
    do_read();
    send_frame(9'h0E1, 8, 1, 1, 1, 1'b1);
    check("R4 odd bad", parity_err, 1);
    check("R4 odd bad data", rx_data, 8'hE1);
    do_read();
    par_mode = 2'b01;
    send_frame(9'h05A, 8, 0, 0, 0, 1'b1);
    check("R4 reserved no parity", {frame_err, parity_err}, 0);
    check("R4 reserved data", rx_data, 8'h5A);
    do_read();
    par_mode = 2'b00;
  endtask

  task automatic t_frame();
    send_frame(9'h081, 8, 0, 0, 0, 1'b0);
    check("R5 ferr set", frame_err, 1);
    check("R5 data", rx_data, 8'h81);
    do_read();
    check("R8 ferr cleared", frame_err, 0);
    send_frame(9'h042, 8, 0, 0, 0, 1'b1);
    check("R5 ferr clean", frame_err, 0);
    do_read();
  endtask

  task automatic t_overrun();
    send_frame(9'h011, 8, 0, 0, 0, 1'b1);
    send_frame(9'h022, 8, 0, 0, 0, 1'b1);
    check("R7 overrun", overrun, 1);
    check("R7 new data", rx_data, 8'h22);
    do_read();
    check("R8 ovr cleared", overrun, 0);
    send_frame(9'h033, 8, 0, 0, 0, 1'b1);
    check("R7 no overrun after read", overrun, 0);
    do_read();
  endtask

  task automatic t_glitch();
    @(negedge clk) rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    idle_bits(12);
    check("R2 glitch ignored", rx_ready, 0);
    send_frame(9'h06C, 8, 0, 0, 0, 1'b1);
    check("R2 after glitch", rx_data, 8'h6C);
    check("R2 ready after glitch", rx_ready, 1);
    do_read();
  endtask

  task automatic t_disable();
    rx_en = 1'b0;
    send_frame(9'h044, 8, 0, 0, 0, 1'b1);
    check("R9 disabled", rx_ready, 0);
    rx_en = 1'b1;
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b0);
    rx_en = 1'b0;
    for (int i = 0; i < 6; i++) drive_bit(1'b1);
    idle_bits(2);
    rx_en = 1'b1;
    idle_bits(2);
    check("R9 abandoned", rx_ready, 0);
    send_frame(9'h099, 8, 0, 0, 0, 1'b1);
    check("R9 re-enabled", rx_data, 8'h99);
    do_read();
  endtask

  task automatic t_div();
    baud_div = 12'd3;
    idle_bits(2);
    send_frame(9'h0C6, 8, 0, 0, 0, 1'b1);
    check("R10 slow data", rx_data, 8'hC6);
    check("R10 slow ferr", frame_err, 0);
    do_read();
    baud_div = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_bits(2);
    t_basic();
    t_lengths();
    t_parity();
    t_frame();
    t_overrun();
    t_glitch();
    t_disable();
    t_div();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R1-wide run actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule